// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits on the memory side of a small multiprocessor and owns a word-wide register array shared by several requesters. Every granted request runs its read and its write within one clock cycle, and only one request is granted per cycle. The unit can therefore perform lock acquisition, counters and lock-free updates with no chance that another requester's access lands between the read and the write.

Each requester holds a request, which carries an operation code, an address, a data operand and a compare operand, until the unit grants it. A rotating-priority arbiter picks one requester per cycle. In the cycle after the grant the unit returns the old word, or a success flag, tagged with the requester's index. A small table keeps one link reservation per requester, so a linked load followed by a conditional store detects any intervening write to the same word.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every word reads 0, no response is valid, no grant is given and no reservation exists, so a conditional store issued first fails and returns 0.
- R2: At most one grant is asserted per cycle, and only to a requester whose request is valid. The cycle after a grant, rsp_valid is 1 and rsp_id holds the granted index. A cycle with no grant is followed by rsp_valid 0.
- R3: A load (op 0) returns the word and leaves it unchanged. A store (op 1) writes the data operand and returns the previous word.
- R4: Test-and-set (op 2) returns the previous word and writes 1.
- R5: Fetch-and-add (op 3) returns the previous word and writes the previous word plus the data operand, modulo 2^DW.
- R6: Compare-and-swap (op 4) writes the data operand only when the word equals the compare operand, and always returns the word it read.
- R7: Load-linked (op 5) returns the word and reserves that address for the requester. A following store-conditional (op 6) by the same requester writes the data operand and returns 1.
- R8: Any write to an address by any requester, through a store, test-and-set, fetch-and-add, successful compare-and-swap or successful store-conditional, cancels every reservation on that address. A store-conditional then returns 0 and does not write. A write to a different address leaves the reservation intact.
- R9: A store-conditional cancels the requester's own reservation whether it succeeds or fails, so a second one without a new load-linked returns 0.
- R10: Priority rotates to the index after the last grant. With all requesters waiting, each one is served exactly once within NREQ cycles. Two simultaneous test-and-sets on a free lock give exactly one requester 0.
- R11: Releasing a lock is a plain store of 0, after which test-and-set returns 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request pending |
| req_op | input | 3*NREQ | Per-requester operation code, 3 bits each |
| req_addr | input | AW*NREQ | Per-requester word address |
| req_wdata | input | DW*NREQ | Per-requester data operand (store data, addend, swap value) |
| req_cmp | input | DW*NREQ | Per-requester compare operand for compare-and-swap |
| grant | output | NREQ | One-hot grant for the current cycle |
| rsp_valid | output | 1 | Response valid, one cycle after the grant |
| rsp_id | output | $clog2(NREQ) | Index of the requester that owns the response |
| rsp_data | output | DW | Old word, or success flag for store-conditional |

## Verification
The hardest case to reach is a reservation broken between a load-linked and its store-conditional. A sequence of single-requester calls alone never produces it. The stimulus therefore places a foreign store to a neighbouring address and, separately, a foreign fetch-and-add to the reserved address between the two halves of the pair. It then checks both the flag and the word. The lock race is recreated by raising two test-and-set requests on the same negative edge, so that the arbiter has to serialise them.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [3*NREQ-1:0] req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  input  logic [DW*NREQ-1:0] req_cmp,
  output logic [NREQ-1:0]   grant,
  output logic              rsp_valid,
  output logic [IW-1:0]     rsp_id,
  output logic [DW-1:0]     rsp_data
);
  localparam logic [2:0] OP_LD  = 3'd0, OP_ST = 3'd1, OP_TAS = 3'd2, OP_FADD = 3'd3,
                         OP_CAS = 3'd4, OP_LL = 3'd5, OP_SC  = 3'd6;

  logic [DW-1:0] mem [DEPTH];
  logic [NREQ-1:0] resv_v;
  logic [AW-1:0]   resv_a [NREQ];
  logic [IW-1:0]   ptr;

  logic          any;
  logic [IW-1:0] win;
  always_comb begin
    any = 1'b0;
    win = ptr;
    for (int k = NREQ - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr) + k) % NREQ;
      if (req_valid[idx]) begin
        any = 1'b1;
        win = IW'(idx);
      end
    end
  end

  assign grant = any ? (NREQ'(1) << win) : '0;

  logic [2:0]    sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wd, sel_cmp, old_val;
  assign sel_op   = req_op[3*win +: 3];
  assign sel_addr = req_addr[AW*win +: AW];
  assign sel_wd   = req_wdata[DW*win +: DW];
  assign sel_cmp  = req_cmp[DW*win +: DW];
  assign old_val  = mem[sel_addr];

  logic          link_ok;
  assign link_ok = resv_v[win] && (resv_a[win] == sel_addr);

  logic          we;
  logic [DW-1:0] wval, rdata;
  always_comb begin
    we    = 1'b0;
    wval  = sel_wd;
    rdata = old_val;
    case (sel_op)
      OP_ST:   we = 1'b1;
      OP_TAS:  begin we = 1'b1; wval = DW'(1); end
      OP_FADD: begin we = 1'b1; wval = old_val + sel_wd; end
      OP_CAS:  we = (old_val == sel_cmp);
      OP_SC:   begin we = link_ok; rdata = DW'(link_ok); end
      default: ;
    endcase
    if (!any) we = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < NREQ; j++) resv_a[j] <= '0;
      resv_v    <= '0;
      ptr       <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= any;
      if (any) begin
        rsp_id   <= win;
        rsp_data <= rdata;
        ptr      <= (int'(win) == NREQ - 1) ? '0 : win + 1'b1;
      end
      if (we) mem[sel_addr] <= wval;
      for (int j = 0; j < NREQ; j++)
        if (we && resv_a[j] == sel_addr) resv_v[j] <= 1'b0;
      if (any && sel_op == OP_LL) begin
        resv_v[win] <= 1'b1;
        resv_a[win] <= sel_addr;
      end
      if (any && sel_op == OP_SC) resv_v[win] <= 1'b0;
    end
  end
endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
  parameter int NREQ = 4,
  parameter int IW   = 2,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] grant,
  input logic            rsp_valid,
  input logic [IW-1:0]   rsp_id,
  input logic [DW-1:0]   rsp_data,
  input logic [2:0]      sel_op
);
  logic [NREQ-1:0] g_q;
  logic            sc_q;
  int              wait_cnt [NREQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q  <= '0;
      sc_q <= 1'b0;
      for (int i = 0; i < NREQ; i++) wait_cnt[i] <= 0;
    end else begin
      g_q  <= grant;
      sc_q <= (|grant) && sel_op == 3'd6;
      for (int i = 0; i < NREQ; i++)
        wait_cnt[i] <= (req_valid[i] && !grant[i]) ? wait_cnt[i] + 1 : 0;
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);
  assert_rsp_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid);
  assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_valid);
  assert_rsp_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> g_q[rsp_id]);
  assert_sc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && sc_q) |-> rsp_data <= DW'(1));
  for (genvar i = 0; i < NREQ; i++) begin : g_starve
    assert_no_starve_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt[i] < NREQ);
  end
endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.NREQ(NREQ), .IW(IW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .sel_op(sel_op)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 4, AW = 4, DW = 16, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [3*NREQ-1:0]  req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0, req_cmp = '0;
  logic [NREQ-1:0] grant;
  logic rsp_valid;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  int total = 0, bad = 0;
  logic [DW-1:0] res [NREQ];
  int served [NREQ];
  int order [NREQ];
  int nresp;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_rmw_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) dut (.*);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic multi(input logic [NREQ-1:0] mask, input logic [2:0] op,
                       input logic [AW-1:0] addr, input logic [DW-1:0] wd, input logic [DW-1:0] cmp);
    logic [NREQ-1:0] g;
    @(negedge clk);
    for (int i = 0; i < NREQ; i++) begin
      served[i] = -1;
      if (mask[i]) begin
        req_op[3*i +: 3] = op; req_addr[AW*i +: AW] = addr;
        req_wdata[DW*i +: DW] = wd; req_cmp[DW*i +: DW] = cmp;
      end
    end
    req_valid = mask;
    nresp = 0;
    for (int c = 0; c < NREQ + 2; c++) begin
      #1 g = grant;
      @(negedge clk);
      req_valid = req_valid & ~g;
      if (rsp_valid) begin
        res[rsp_id] = rsp_data;
        served[rsp_id] = c;
        if (nresp < NREQ) order[nresp] = int'(rsp_id);
        nresp++;
      end
    end
    req_valid = '0;
  endtask

  task automatic op1(input int id, input logic [2:0] op, input logic [AW-1:0] addr,
                     input logic [DW-1:0] wd, input logic [DW-1:0] cmp, output logic [DW-1:0] r);
    multi(NREQ'(1) << id, op, addr, wd, cmp);
    r = (served[id] >= 0) ? res[id] : 'x;
  endtask

  task automatic t_reset;
    logic [DW-1:0] r;
    #1;
    check("R1 rsp_valid after reset", DW'(rsp_valid), 0);
    check("R1 grant idle", DW'(grant), 0);
    op1(2, 3'd0, 4'd3, 0, 0, r); check("R1 word zero", r, 0);
    op1(1, 3'd6, 4'd3, 16'h55, 0, r); check("R1 sc without reservation", r, 0);
    op1(1, 3'd0, 4'd3, 0, 0, r); check("R1 failed sc no write", r, 0);
  endtask

  task automatic t_load_store;
    logic [DW-1:0] r;
    op1(0, 3'd1, 4'd2, 16'h0005, 0, r); check("R3 store returns old", r, 0);
    op1(3, 3'd0, 4'd2, 0, 0, r); check("R3 load sees store", r, 16'h0005);
    check("R2 rsp_id owner", DW'(served[3] >= 0), 1);
  endtask

  task automatic t_tas;
    logic [DW-1:0] r;
    op1(1, 3'd2, 4'd7, 0, 0, r); check("R4 tas free lock", r, 0);
    op1(2, 3'd2, 4'd7, 0, 0, r); check("R4 tas held lock", r, 1);
    op1(1, 3'd1, 4'd7, 0, 0, r);
    op1(2, 3'd2, 4'd7, 0, 0, r); check("R11 tas after release", r, 0);
  endtask

  task automatic t_fadd;
    logic [DW-1:0] r;
    op1(0, 3'd1, 4'd4, 16'hFFFE, 0, r);
    op1(1, 3'd3, 4'd4, 16'd3, 0, r); check("R5 fadd old", r, 16'hFFFE);
    op1(2, 3'd0, 4'd4, 0, 0, r); check("R5 fadd wraps", r, 16'h0001);
  endtask

  task automatic t_cas;
    logic [DW-1:0] r;
    op1(0, 3'd1, 4'd5, 16'd10, 0, r);
    op1(1, 3'd4, 4'd5, 16'd20, 16'd9, r); check("R6 cas mismatch returns old", r, 16'd10);
    op1(1, 3'd0, 4'd5, 0, 0, r); check("R6 cas mismatch no write", r, 16'd10);
    op1(2, 3'd4, 4'd5, 16'd20, 16'd10, r); check("R6 cas match returns old", r, 16'd10);
    op1(2, 3'd0, 4'd5, 0, 0, r); check("R6 cas match writes", r, 16'd20);
  endtask

  task automatic t_llsc;
    logic [DW-1:0] r;
    op1(0, 3'd5, 4'd6, 0, 0, r); check("R7 ll value", r, 0);
    op1(0, 3'd6, 4'd6, 16'd33, 0, r); check("R7 sc success", r, 1);
    op1(1, 3'd0, 4'd6, 0, 0, r); check("R7 sc wrote", r, 16'd33);
    op1(0, 3'd6, 4'd6, 16'd44, 0, r); check("R9 second sc fails", r, 0);
    op1(1, 3'd0, 4'd6, 0, 0, r); check("R9 second sc no write", r, 16'd33);
  endtask

  task automatic t_ll_broken;
    logic [DW-1:0] r;
    op1(0, 3'd5, 4'd6, 0, 0, r);
    op1(1, 3'd1, 4'd9, 16'd1, 0, r);
    op1(0, 3'd6, 4'd6, 16'd50, 0, r); check("R8 other address keeps reservation", r, 1);
    op1(0, 3'd5, 4'd6, 0, 0, r);
    op1(3, 3'd5, 4'd6, 0, 0, r);
    op1(2, 3'd3, 4'd6, 16'd2, 0, r);
    op1(0, 3'd6, 4'd6, 16'd77, 0, r); check("R8 foreign fadd breaks link", r, 0);
    op1(3, 3'd6, 4'd6, 16'd78, 0, r); check("R8 all links on word cleared", r, 0);
    op1(1, 3'd0, 4'd6, 0, 0, r); check("R8 failed sc no write", r, 16'd52);
  endtask

  task automatic t_contend;
    multi(4'b1001, 3'd2, 4'd8, 0, 0);
    check("R10 both tas served", DW'(served[0] >= 0 && served[3] >= 0), 1);
    check("R10 exactly one acquires", DW'(res[0] ^ res[3]), 1);
    check("R10 serialised in two cycles", DW'(served[0] != served[3] && served[0] <= 1 && served[3] <= 1), 1);
  endtask

  task automatic t_rr;
    logic [NREQ-1:0] seen;
    multi(4'b1111, 3'd0, 4'd2, 0, 0);
    seen = '0;
    for (int i = 0; i < NREQ; i++) seen[order[i]] = 1'b1;
    check("R10 each served once", DW'(seen), DW'(4'b1111));
    check("R10 responses count", DW'(nresp), NREQ);
    for (int i = 1; i < NREQ; i++)
      check("R10 rotation order", DW'(order[i]), DW'((order[i-1] + 1) % NREQ));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_load_store();
    t_tas();
    t_fadd();
    t_cas();
    t_llsc();
    t_ll_broken();
    t_contend();
    t_rr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule